// File: doc/BRIEF.md
# Single-Precision Add-Immediate Execution Unit

This unit carries out one floating-point instruction: it adds a value held in a four-entry register file to a constant carried inside the instruction word, and writes the sum back into the register file. The constant is only 16 bits wide. It supplies the sign, the exponent and the top seven fraction bits of an IEEE-754 single-precision number, and the unit fills the lower half of the number with zeros. This form covers common constants such as 0.5, 2.0 and -1.5.

On an issue strobe, the unit checks the opcode bits in the instruction word. It picks the source and destination registers from two 2-bit fields, widens the constant, and adds the two operands with round-to-nearest-even. The destination register takes the sum on the next clock edge. In the same edge, two sticky status bits record overflow and underflow. The other three status bits are never written by the instruction.

Two side ports let the surrounding pipeline preload registers and the status word. A read port lets it observe any register.

Top module: `fpa_addi_unit`

## Requirements
- R1: The second operand is {instr[15:0], 16'h0000}. The sum of that operand and the source register is written to the destination register on the clock edge where `issue_i` is sampled high.
- R2: An instruction is valid when instr[31:20] == 12'h77C. instr[19:18] selects the source register and instr[17:16] selects the destination register. Source and destination may be the same register.
- R3: Rounding is round-to-nearest, ties-to-even.
- R4: A sum whose magnitude is too large becomes an infinity with the correct sign, and sets status bit 4 (overflow).
- R5: Operands whose exponent field is zero are treated as zero. A nonzero sum smaller than the smallest normal magnitude becomes a zero with the correct sign, and sets status bit 3 (underflow).
- R6: Status bits 4 and 3 are sticky. The instruction never clears them. Only `flag_clr_i` (synchronous) or reset clears them.
- R7: Status bits 2:0 (negative, zero and test) are never changed by the instruction.
- R8: With `issue_i` high and the opcode bits not matching, no register and no status bit changes. `illegal_o` is high for exactly the following cycle.
- R9: A NaN operand, or infinities of opposite sign, give the quiet NaN 32'h7FC00000. An infinity plus a finite value gives that infinity and sets no flag. An exact cancellation gives +0.
- R10: Reset (synchronous, active high) clears all registers, all status bits and `illegal_o`.
- R11: `ld_en_i` writes `ld_data_i` into register `ld_sel_i`. If an instruction writes the same register in the same cycle, the instruction's result wins. `stat_wr_i` loads all five status bits from `stat_i`, and takes priority over instruction flag updates and over `flag_clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction issue strobe |
| instr_i | input | 32 | Instruction word |
| flag_clr_i | input | 1 | Clears the sticky overflow/underflow bits |
| ld_en_i | input | 1 | Register preload enable |
| ld_sel_i | input | 2 | Register preload index |
| ld_data_i | input | 32 | Register preload value |
| stat_wr_i | input | 1 | Status word load enable |
| stat_i | input | 5 | Status load value {ovf, unf, neg, zero, test} |
| rd_sel_i | input | 2 | Observation read index |
| rd_data_o | output | 32 | Observation read data |
| stat_o | output | 5 | Status word {ovf, unf, neg, zero, test} |
| illegal_o | output | 1 | One-cycle pulse after an unrecognised issue |

## Verification
The adder is tried with several kinds of operand pairs, each aimed at a different piece of logic.
- Small exact sums and an exact cancellation exercise alignment and the sign of zero.
- Constants near 2^23 and 2^24 probe rounding. Operands placing the discarded part below a half, at a tie with an even result, at a tie with an odd result and above a half separate true ties-to-even from truncation or round-half-up.
- Largest-magnitude operands of both signs check overflow, and the sign of the resulting infinity.
- Sums just below the normal range, of either sign, check flushing and the sign of the flushed zero.
- Subnormal, NaN and infinity operands cover the special paths.
- Mismatched opcodes, preloaded test/zero/negative bits and a same-cycle preload collision check that the instruction only ever touches the state it owns.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    localparam int SEL_W  = 2;
    localparam int NREG   = 1 << SEL_W;
    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int OPC_W  = XLEN - IMM_W - 2 * SEL_W;
    localparam logic [OPC_W-1:0] OPC_ADDI = 12'h77C;
    localparam logic [XLEN-1:0]  QNAN     = 32'h7FC0_0000;

    typedef struct packed {
        logic        sign;
        logic [7:0]  exp;
        logic [22:0] frac;
    } fp32_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic neg;
        logic zero;
        logic test;
    } stat_t;

    typedef struct packed {
        logic             match;
        logic [SEL_W-1:0] src;
        logic [SEL_W-1:0] dst;
        logic [XLEN-1:0]  opb;
    } dec_t;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm);
        return {imm, {(XLEN-IMM_W){1'b0}}};
    endfunction

    function automatic logic [4:0] lzc27(input logic [26:0] v);
        logic [4:0] n;
        logic       hit;
        n   = '0;
        hit = 1'b0;
        for (int i = 26; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 5'd1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpa_decode.sv
module fpa_decode
    import fpa_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output dec_t            dec_o
);
    localparam int DST_LO = IMM_W;
    localparam int SRC_LO = IMM_W + SEL_W;
    localparam int OPC_LO = IMM_W + 2 * SEL_W;

    always_comb begin
        dec_o.match = (instr_i[XLEN-1:OPC_LO] == OPC_ADDI);
        dec_o.src   = instr_i[SRC_LO +: SEL_W];
        dec_o.dst   = instr_i[DST_LO +: SEL_W];
        dec_o.opb   = widen_imm(instr_i[IMM_W-1:0]);
    end
endmodule

// File: rtl/fpa_regfile.sv
module fpa_regfile #(
    parameter int N = 4,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_x,
    input  logic [AW-1:0] wa_x,
    input  logic [W-1:0]  wd_x,
    input  logic          we_l,
    input  logic [AW-1:0] wa_l,
    input  logic [W-1:0]  wd_l,
    input  logic [AW-1:0] ra_s,
    output logic [W-1:0]  rd_s,
    input  logic [AW-1:0] ra_d,
    output logic [W-1:0]  rd_d
);
    logic [N-1:0][W-1:0] mem;

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we_x && wa_x == AW'(g))   // execution result beats preload (R11)
                mem[g] <= wd_x;
            else if (we_l && wa_l == AW'(g))
                mem[g] <= wd_l;
        end
    end

    assign rd_s = mem[ra_s];
    assign rd_d = mem[ra_d];

    // R8: with neither write port active, no entry may change
    a_r8_rf_hold: assert property (@(posedge clk) disable iff (rst)
        (!we_x && !we_l) |=> $stable(mem));
endmodule

// File: rtl/fpa_add32.sv
module fpa_add32
    import fpa_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] sum_o,
    output logic            ovf_o,
    output logic            unf_o
);
    fp32_t             a, b, big, sml;
    logic              a_z, b_z, a_inf, b_inf, a_nan, b_nan;
    logic [7:0]        dexp;
    logic [49:0]       wide;
    logic [26:0]       mbig, msml, nrm;
    logic [27:0]       acc;
    logic [4:0]        lz;
    logic signed [9:0] e;
    logic              rup;
    logic [24:0]       rnd;

    always_comb begin
        a     = a_i;
        b     = b_i;
        a_z   = (a.exp == 8'h00);
        b_z   = (b.exp == 8'h00);
        a_inf = (a.exp == 8'hFF) && (a.frac == '0);
        b_inf = (b.exp == 8'hFF) && (b.frac == '0);
        a_nan = (a.exp == 8'hFF) && (a.frac != '0);
        b_nan = (b.exp == 8'hFF) && (b.frac != '0);

        // order operands by magnitude
        if ({a.exp, a.frac} >= {b.exp, b.frac}) begin
            big = a; sml = b;
        end else begin
            big = b; sml = a;
        end

        // align the smaller operand, keeping guard, round and sticky bits
        dexp = big.exp - sml.exp;
        wide = {1'b1, sml.frac, 26'b0} >> dexp;
        mbig = {1'b1, big.frac, 3'b000};
        msml = {wide[49:24], wide[23] | (|wide[22:0])};
        acc  = (big.sign == sml.sign) ? ({1'b0, mbig} + {1'b0, msml})
                                      : ({1'b0, mbig} - {1'b0, msml});

        // normalise
        e  = $signed({2'b00, big.exp});
        lz = '0;
        if (acc[27]) begin
            nrm = {acc[27:2], acc[1] | acc[0]};
            e   = e + 10'sd1;
        end else begin
            lz  = lzc27(acc[26:0]);
            nrm = acc[26:0] << lz;
            e   = e - $signed({5'b00000, lz});
        end

        // round to nearest, ties to even
        rup = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
        rnd = {1'b0, nrm[26:3]} + {24'b0, rup};
        if (rnd[24]) begin
            rnd = rnd >> 1;
            e   = e + 10'sd1;
        end

        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (a_nan || b_nan || (a_inf && b_inf && (a.sign != b.sign)))
            sum_o = QNAN;
        else if (a_inf)
            sum_o = a_i;
        else if (b_inf)
            sum_o = b_i;
        else if (a_z && b_z)
            sum_o = {a.sign & b.sign, 31'b0};
        else if (a_z)
            sum_o = b_i;
        else if (b_z)
            sum_o = a_i;
        else if (acc == '0)
            sum_o = '0;
        else if (e >= 10'sd255) begin
            ovf_o = 1'b1;
            sum_o = {big.sign, 8'hFF, 23'b0};
        end else if (e <= 10'sd0) begin
            unf_o = 1'b1;
            sum_o = {big.sign, 31'b0};
        end else
            sum_o = {big.sign, e[7:0], rnd[22:0]};
    end
endmodule

// File: rtl/fpa_addi_unit.sv
module fpa_addi_unit
    import fpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic [XLEN-1:0]  instr_i,
    input  logic             flag_clr_i,
    input  logic             ld_en_i,
    input  logic [SEL_W-1:0] ld_sel_i,
    input  logic [XLEN-1:0]  ld_data_i,
    input  logic             stat_wr_i,
    input  logic [4:0]       stat_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [XLEN-1:0]  rd_data_o,
    output logic [4:0]       stat_o,
    output logic             illegal_o
);
    dec_t            dec;
    logic            exec, bad;
    logic [XLEN-1:0] src_val, sum;
    logic            add_ovf, add_unf;
    stat_t           stat_q;
    logic            ill_q;

    fpa_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    assign exec = issue_i &  dec.match;
    assign bad  = issue_i & ~dec.match;

    fpa_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk (clk),       .rst (rst),
        .we_x(exec),      .wa_x(dec.dst),  .wd_x(sum),
        .we_l(ld_en_i),   .wa_l(ld_sel_i), .wd_l(ld_data_i),
        .ra_s(dec.src),   .rd_s(src_val),
        .ra_d(rd_sel_i),  .rd_d(rd_data_o)
    );

    fpa_add32 u_add (
        .a_i(src_val), .b_i(dec.opb),
        .sum_o(sum), .ovf_o(add_ovf), .unf_o(add_unf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ill_q  <= 1'b0;
        end else begin
            ill_q <= bad;
            if (stat_wr_i)
                stat_q <= stat_t'(stat_i);
            else begin
                stat_q.ovf <= (stat_q.ovf & ~flag_clr_i) | (exec & add_ovf);
                stat_q.unf <= (stat_q.unf & ~flag_clr_i) | (exec & add_unf);
            end
        end
    end

    assign stat_o    = stat_q;
    assign illegal_o = ill_q;

    // R6: a set sticky flag survives unless cleared or reloaded
    a_r6_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
        (stat_q.ovf && !flag_clr_i && !stat_wr_i) |=> stat_q.ovf);
    a_r6_sticky_unf: assert property (@(posedge clk) disable iff (rst)
        (stat_q.unf && !flag_clr_i && !stat_wr_i) |=> stat_q.unf);
    // R6: clearing with no new event leaves the flags low
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i && !stat_wr_i && !exec) |=> (!stat_q.ovf && !stat_q.unf));
    // R7: the instruction never touches the negative/zero/test bits
    a_r7_nzt_stable: assert property (@(posedge clk) disable iff (rst)
        !stat_wr_i |=> $stable(stat_o[2:0]));
    // R8: a mismatched issue pulses illegal and leaves status alone
    a_r8_illegal: assert property (@(posedge clk) disable iff (rst)
        (bad && !stat_wr_i && !flag_clr_i) |=> (illegal_o && $stable(stat_o)));
    // R4: an overflowing add produces an infinity
    a_r4_ovf_inf: assert property (@(posedge clk) disable iff (rst)
        add_ovf |-> (sum[30:0] == 31'h7F80_0000));
    // R5: a flushed result is a zero
    a_r5_unf_zero: assert property (@(posedge clk) disable iff (rst)
        add_unf |-> (sum[30:0] == 31'h0));
endmodule

// File: tb/sim_fpa_addi_unit.sv
module sim_fpa_addi_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_i, flag_clr_i, ld_en_i, stat_wr_i;
    logic [31:0] instr_i, ld_data_i;
    logic [1:0]  ld_sel_i, rd_sel_i;
    logic [4:0]  stat_i;
    logic [31:0] rd_data_o;
    logic [4:0]  stat_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] val;
        logic [4:0]  st;
        logic        ill;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    fpa_addi_unit u0 (.*);

    function automatic logic [31:0] mk(input logic [1:0] s, input logic [1:0] d,
                                       input logic [15:0] imm);
        return {12'h77C, s, d, imm};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_reg(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        ld_en_i = 1; ld_sel_i = s; ld_data_i = v;
        @(negedge clk);
        ld_en_i = 0;
    endtask

    task automatic load_stat(input logic [4:0] v);
        @(negedge clk);
        stat_wr_i = 1; stat_i = v;
        @(negedge clk);
        stat_wr_i = 0;
    endtask

    // driver: issue one word, push the expected outcome
    task automatic run(input logic [31:0] w, input logic [1:0] view,
                       input logic [31:0] ev, input logic [4:0] es,
                       input logic eill, input string tag);
        item_t it;
        @(negedge clk);
        issue_i = 1; instr_i = w; rd_sel_i = view;
        it.val = ev; it.st = es; it.ill = eill; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        issue_i = 0;
    endtask

    // monitor: compare after the edge that consumed the issue
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk({it.tag, " result"}, rd_data_o, it.val);
                chk({it.tag, " status"}, {27'b0, stat_o}, {27'b0, it.st});
                chk({it.tag, " illegal"}, {31'b0, illegal_o}, {31'b0, it.ill});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; issue_i = 0; instr_i = 0; flag_clr_i = 0; ld_en_i = 0;
        ld_sel_i = 0; ld_data_i = 0; stat_wr_i = 0; stat_i = 0; rd_sel_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        for (int i = 0; i < 4; i++) begin
            rd_sel_i = 2'(i);
            #1 chk("R10 reg", rd_data_o, 32'h0);
        end
        chk("R10 stat", {27'b0, stat_o}, 32'h0);
        chk("R10 illegal", {31'b0, illegal_o}, 32'h0);

        // R1 R2: 1.0 + 2.0 = 3.0, then same source and destination
        load_reg(0, 32'h3F80_0000);
        run(mk(0, 1, 16'h4000), 1, 32'h4040_0000, 5'b00000, 0, "R1");
        run(mk(0, 0, 16'h4000), 0, 32'h4040_0000, 5'b00000, 0, "R2");
        // R9: exact cancellation gives +0
        load_reg(2, 32'hBFC0_0000);
        run(mk(2, 3, 16'h3FC0), 3, 32'h0000_0000, 5'b00000, 0, "R9 cancel");
        // R3: below half, tie-even, tie-odd, above half
        load_reg(0, 32'h3F80_0001);
        run(mk(0, 1, 16'h4B00), 1, 32'h4B00_0001, 5'b00000, 0, "R3 below");
        load_reg(0, 32'h3F80_0000);
        run(mk(0, 1, 16'h4B80), 1, 32'h4B80_0000, 5'b00000, 0, "R3 tie even");
        load_reg(0, 32'h4040_0000);
        run(mk(0, 2, 16'h4B80), 2, 32'h4B80_0002, 5'b00000, 0, "R3 tie odd");
        load_reg(0, 32'h3FC0_0000);
        run(mk(0, 2, 16'h4B80), 2, 32'h4B80_0001, 5'b00000, 0, "R3 above");
        // R5: subnormal input counts as zero
        load_reg(1, 32'h0000_0001);
        run(mk(1, 2, 16'h3F80), 2, 32'h3F80_0000, 5'b00000, 0, "R5 denorm in");
        // R7 R11: preset neg/zero/test bits, instruction keeps them
        load_stat(5'b00101);
        run(mk(0, 3, 16'h3F80), 3, 32'h4020_0000, 5'b00101, 0, "R7");
        // R4: overflow both signs
        load_reg(2, 32'h7F7F_FFFF);
        run(mk(2, 3, 16'h7F7F), 3, 32'h7F80_0000, 5'b10101, 0, "R4 pos");
        // R6: a clean add leaves overflow set
        run(mk(0, 1, 16'h3F80), 1, 32'h4020_0000, 5'b10101, 0, "R6 sticky");
        load_reg(2, 32'hFF7F_FFFF);
        run(mk(2, 0, 16'hFF7F), 0, 32'hFF80_0000, 5'b10101, 0, "R4 neg");
        // R6: synchronous clear
        @(negedge clk); flag_clr_i = 1;
        @(negedge clk); flag_clr_i = 0;
        chk("R6 clear", {27'b0, stat_o}, {27'b0, 5'b00101});
        // R5: flush to signed zero
        load_reg(3, 32'h00C0_0000);
        run(mk(3, 1, 16'h8080), 1, 32'h0000_0000, 5'b01101, 0, "R5 pos");
        load_reg(3, 32'h80C0_0000);
        run(mk(3, 1, 16'h0080), 1, 32'h8000_0000, 5'b01101, 0, "R5 neg");
        // R8: mismatched opcode changes nothing, pulses once
        load_reg(0, 32'h3F80_0000);
        run({12'h77D, 2'd0, 2'd1, 16'h4000}, 1, 32'h8000_0000, 5'b01101, 1, "R8");
        @(negedge clk);
        chk("R8 pulse end", {31'b0, illegal_o}, 32'h0);
        // R9: NaN, opposite infinities, infinity plus finite
        load_reg(2, 32'h7FC1_2345);
        run(mk(2, 3, 16'h3F80), 3, 32'h7FC0_0000, 5'b01101, 0, "R9 nan");
        load_reg(2, 32'h7F80_0000);
        run(mk(2, 3, 16'hFF80), 3, 32'h7FC0_0000, 5'b01101, 0, "R9 inf-inf");
        run(mk(2, 3, 16'h3F80), 3, 32'h7F80_0000, 5'b01101, 0, "R9 inf+1");
        // R11: same-cycle preload collision, instruction wins
        @(negedge clk);
        issue_i = 1; instr_i = mk(0, 2, 16'h4000); rd_sel_i = 2;
        ld_en_i = 1; ld_sel_i = 2; ld_data_i = 32'h1234_5678;
        @(negedge clk);
        issue_i = 0; ld_en_i = 0;
        chk("R11 collide", rd_data_o, 32'h4040_0000);
        // R11: status load
        load_stat(5'b10010);
        chk("R11 stat load", {27'b0, stat_o}, {27'b0, 5'b10010});

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule